// File: doc/BRIEF.md
# Sector Hamming Parity Generator

This block sits beside the byte path of a NAND flash controller. It builds single-error-correcting Hamming parity over a 512-byte sector while the bytes move through that path. The sector is treated as two separate 256-byte halves. Each half gives a 3-byte code: sixteen line-parity bits and six column-parity bits. All parity bits are inverted, so an erased half (all 0xFF) gives a code of all ones.

Software drives the block by writing 8-bit mode codes. The codes do three things: clear the accumulators, accumulate every byte that is transferred, and switch the data port so that it returns the two codes as three 16-bit words. Correcting errors from the codes is left to software.

Top module: `necc_top`

## Requirements
- R1: After reset, `res_mode` is 0 and `res_word` reads 16'hFFFF, which is the code of an empty accumulation.
- R2: Mode code 0xF4 clears both accumulators and the byte count. A byte transferred while this mode is active, such as the dummy read that follows a clear, changes nothing.
- R3: Mode code 0xB4 accumulates each transferred byte. Column bits are parities over bit masks: CP0 uses 0x55, CP1 uses 0xAA, CP2 uses 0x33, CP3 uses 0xCC, CP4 uses 0x0F and CP5 uses 0xF0. Line bit LP(2k+v) is the parity of every byte in the half whose in-half index has bit k equal to v, for k from 0 to 7.
- R4: Bytes 0 to 255 after a clear go into code A. Bytes 256 to 511 go into code B.
- R5: Bytes after the 512th are ignored until the next clear.
- R6: Each code is {~LP15..8, ~LP7..0, {~CP5..CP0, 2'b11}}, written as byte 0, byte 1, byte 2. The two low bits of byte 2 are always 1.
- R7: The result words are packed as follows: word 0 = {A byte0, A byte1}, word 1 = {B byte1, A byte2}, word 2 = {B byte2, B byte0}. The high byte is named first in each word.
- R8: Mode code 0xD4 sets `res_mode` and points at word 0. Each `res_rd` pulse moves to the next word, and the pointer wraps from word 2 back to word 0.
- R9: Any other mode code, including 0xF4 and 0x94, clears `res_mode`. Bytes sent while the block is not in 0xB4 mode are not accumulated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_we | input | 1 | Mode code write strobe |
| mode_val | input | 8 | Mode code |
| byte_vld | input | 1 | A byte crosses the flash data path this cycle |
| byte_val | input | 8 | That byte |
| res_rd | input | 1 | 16-bit result read strobe |
| res_mode | output | 1 | Data port is in result read-back |
| res_word | output | 16 | Result word at the read pointer |

## Verification
The generator is tried with several input patterns, and each pattern separates different faults:
- Random sectors check the full parity mapping.
- An erased sector shows whether the inversion is present.
- A sector holding a single set bit at chosen byte positions shows a wrong line-bit index, a swapped column mask, or a misplaced half boundary.
- Sectors that are longer than 512 bytes, shorter than 256 bytes, or interleaved with bytes sent in other modes test the cap, a partial half, and the mode gating.
- Reading a fourth word checks that the pointer wraps.

// File: rtl/necc_pkg.sv
package necc_pkg;
  parameter int IDX_W  = 8;              // byte index bits inside one half
  parameter int HALVES = 2;              // halves per sector
  localparam int HS_W  = $clog2(HALVES);
  localparam int LP_W  = 2 * IDX_W;
  localparam int CP_W  = 6;
  localparam int SECT  = HALVES << IDX_W;
  localparam int CNT_W = IDX_W + HS_W + 1;

  localparam logic [7:0] MODE_CLEAR  = 8'hF4;
  localparam logic [7:0] MODE_CALC   = 8'hB4;
  localparam logic [7:0] MODE_RESULT = 8'hD4;

  typedef enum logic [1:0] {ST_IDLE, ST_CLEAR, ST_CALC, ST_RESULT} necc_state_e;

  // column parity over fixed bit masks of one byte
  function automatic logic [CP_W-1:0] col_par(input logic [7:0] b);
    return {^(b & 8'hF0), ^(b & 8'h0F), ^(b & 8'hCC),
            ^(b & 8'h33), ^(b & 8'hAA), ^(b & 8'h55)};
  endfunction

  // line parity contribution: byte parity lands on one bit per index bit
  function automatic logic [LP_W-1:0] line_par(input logic [7:0] b,
                                                input logic [IDX_W-1:0] idx);
    logic [LP_W-1:0] r;
    logic p;
    r = '0;
    p = ^b;
    for (int k = 0; k < IDX_W; k++) r[2*k + (idx[k] ? 1 : 0)] = p;
    return r;
  endfunction

  // three code bytes {byte0, byte1, byte2}, parity inverted
  function automatic logic [23:0] code_bytes(input logic [LP_W-1:0] lp,
                                              input logic [CP_W-1:0] cp);
    return {~lp[15:8], ~lp[7:0], ~cp, 2'b11};
  endfunction
endpackage

// File: rtl/necc_mode_ctl.sv
module necc_mode_ctl
  import necc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        mode_we,
  input  logic [7:0]  mode_val,
  output necc_state_e state,
  output logic        clr_pulse,
  output logic        go_result
);
  necc_state_e nxt;

  always_comb begin
    case (mode_val)
      MODE_CLEAR:  nxt = ST_CLEAR;
      MODE_CALC:   nxt = ST_CALC;
      MODE_RESULT: nxt = ST_RESULT;
      default:     nxt = ST_IDLE;
    endcase
  end

  assign clr_pulse = mode_we && (mode_val == MODE_CLEAR);
  assign go_result = mode_we && (mode_val == MODE_RESULT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       state <= ST_IDLE;
    else if (mode_we) state <= nxt;
  end
endmodule

// File: rtl/necc_half_acc.sv
module necc_half_acc
  import necc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             en,
  input  logic [IDX_W-1:0] idx,
  input  logic [7:0]       b,
  output logic [LP_W-1:0]  lp,
  output logic [CP_W-1:0]  cp
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lp <= '0;
      cp <= '0;
    end else if (clr) begin
      lp <= '0;
      cp <= '0;
    end else if (en) begin
      lp <= lp ^ line_par(b, idx);
      cp <= cp ^ col_par(b);
    end
  end
endmodule

// File: rtl/necc_result_pack.sv
module necc_result_pack
  import necc_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            restart,
  input  logic            adv,
  input  logic [LP_W-1:0] lp_a,
  input  logic [CP_W-1:0] cp_a,
  input  logic [LP_W-1:0] lp_b,
  input  logic [CP_W-1:0] cp_b,
  output logic [1:0]      rd_ptr,
  output logic [15:0]     word
);
  localparam logic [1:0] LAST = 2'd2;
  logic [23:0] ca, cb;

  assign ca = code_bytes(lp_a, cp_a);
  assign cb = code_bytes(lp_b, cp_b);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rd_ptr <= '0;
    else if (restart) rd_ptr <= '0;
    else if (adv)     rd_ptr <= (rd_ptr == LAST) ? 2'd0 : rd_ptr + 2'd1;
  end

  always_comb begin
    case (rd_ptr)
      2'd0:    word = {ca[23:16], ca[15:8]};
      2'd1:    word = {cb[15:8],  ca[7:0]};
      default: word = {cb[7:0],   cb[23:16]};
    endcase
  end
endmodule

// File: rtl/necc_top.sv
module necc_top (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        mode_we,
  input  logic [7:0]  mode_val,
  input  logic        byte_vld,
  input  logic [7:0]  byte_val,
  input  logic        res_rd,
  output logic        res_mode,
  output logic [15:0] res_word
);
  import necc_pkg::*;

  necc_state_e      state;
  logic             clr_pulse, go_result, acc_fire;
  logic [CNT_W-1:0] cnt;
  logic [HS_W-1:0]  half_sel;
  logic [1:0]       rd_ptr;
  logic [LP_W-1:0]  lp_arr [HALVES];
  logic [CP_W-1:0]  cp_arr [HALVES];

  necc_mode_ctl u_ctl (
    .clk(clk), .rst_n(rst_n), .mode_we(mode_we), .mode_val(mode_val),
    .state(state), .clr_pulse(clr_pulse), .go_result(go_result)
  );

  assign acc_fire = (state == ST_CALC) && byte_vld && !clr_pulse
                    && (cnt < CNT_W'(SECT));
  assign half_sel = cnt[IDX_W +: HS_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt <= '0;
    else if (clr_pulse) cnt <= '0;
    else if (acc_fire)  cnt <= cnt + 1'b1;
  end

  for (genvar h = 0; h < HALVES; h++) begin : g_half
    necc_half_acc u_acc (
      .clk(clk), .rst_n(rst_n), .clr(clr_pulse),
      .en(acc_fire && (half_sel == HS_W'(h))),
      .idx(cnt[IDX_W-1:0]), .b(byte_val),
      .lp(lp_arr[h]), .cp(cp_arr[h])
    );
  end

  assign res_mode = (state == ST_RESULT);

  necc_result_pack u_pack (
    .clk(clk), .rst_n(rst_n), .restart(go_result), .adv(res_rd && res_mode),
    .lp_a(lp_arr[0]), .cp_a(cp_arr[0]), .lp_b(lp_arr[1]), .cp_b(cp_arr[1]),
    .rd_ptr(rd_ptr), .word(res_word)
  );
endmodule

// File: rtl/necc_chk.sv
module necc_chk
  import necc_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             mode_we,
  input logic [7:0]       mode_val,
  input logic             res_mode,
  input logic [15:0]      res_word,
  input logic [CNT_W-1:0] cnt,
  input logic             acc_fire,
  input logic             clr_pulse,
  input logic [1:0]       rd_ptr
);
  assert_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    clr_pulse |=> (cnt == '0));
  assert_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
    acc_fire |=> (cnt == $past(cnt) + 1'b1));
  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == CNT_W'(SECT)) |-> !acc_fire);
  assert_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(SECT));
  assert_fill_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ptr == 2'd1) |-> (res_word[1:0] == 2'b11));
  assert_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ptr != 2'd3);
  assert_enter_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_we && mode_val == MODE_RESULT) |=> (res_mode && rd_ptr == 2'd0));
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_we |=> $stable(res_mode));
endmodule

bind necc_top necc_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mode_we(mode_we), .mode_val(mode_val),
  .res_mode(res_mode), .res_word(res_word), .cnt(cnt), .acc_fire(acc_fire),
  .clr_pulse(clr_pulse), .rd_ptr(rd_ptr)
);

// File: tb/sim_necc_top.sv
module sim_necc_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic mode_we = 0, byte_vld = 0, res_rd = 0;
  logic [7:0] mode_val = 0, byte_val = 0;
  logic res_mode;
  logic [15:0] res_word;

  int n_chk = 0, n_fail = 0;
  logic [7:0] sent [0:1023];
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  necc_top u0 (.clk(clk), .rst_n(rst_n), .mode_we(mode_we), .mode_val(mode_val),
               .byte_vld(byte_vld), .byte_val(byte_val), .res_rd(res_rd),
               .res_mode(res_mode), .res_word(res_word));

  task automatic check(input logic [15:0] act, input logic [15:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic put_mode(input logic [7:0] v);
    @(negedge clk); mode_we = 1; mode_val = v;
    @(negedge clk); mode_we = 0;
  endtask

  task automatic put_byte(input logic [7:0] b);
    @(negedge clk); byte_vld = 1; byte_val = b;
    @(negedge clk); byte_vld = 0;
  endtask

  // code of one half: {byte0, byte1, byte2}
  function automatic logic [23:0] ref_code(input int base, input int n);
    logic [15:0] lp = '0;
    logic [5:0]  cp = '0;
    logic [7:0]  masks [6] = '{8'h55, 8'hAA, 8'h33, 8'hCC, 8'h0F, 8'hF0};
    for (int i = 0; i < n; i++) begin
      for (int j = 0; j < 16; j++)
        if (((i >> (j / 2)) & 1) == (j % 2)) lp[j] ^= ^sent[base + i];
      for (int j = 0; j < 6; j++) cp[j] ^= ^(sent[base + i] & masks[j]);
    end
    return {~lp[15:8], ~lp[7:0], ~cp, 2'b11};
  endfunction

  task automatic read_chk(input logic [15:0] exp, input string tag);
    @(negedge clk);
    check(res_word, exp, tag);
    res_rd = 1;
    @(negedge clk); res_rd = 0;
  endtask

  // kind 0 random, 1 erased, 2 zero with one set byte at pos
  task automatic run_sector(input int kind, input int count, input int pos,
                            input logic [7:0] val, input bit idle_junk, input string tag);
    logic [23:0] ca, cb;
    logic [15:0] w0, w1, w2;
    int used;
    put_mode(8'hF4);
    put_byte(8'($urandom));             // dummy read in clear mode (R2)
    put_mode(8'hB4);
    for (int i = 0; i < count; i++) begin
      logic [7:0] b;
      if (kind == 0)      b = 8'($urandom);
      else if (kind == 1) b = 8'hFF;
      else                b = (i == pos) ? val : 8'h00;
      if (i < 1024) sent[i] = b;
      put_byte(b);
      if (idle_junk && i == count / 2) begin   // R9: bytes in other modes
        put_mode(8'h94);
        put_byte(8'($urandom));
        put_mode(8'h95);
        put_byte(8'($urandom));
        put_mode(8'hB4);
      end
    end
    if (idle_junk) begin put_mode(8'h94); put_byte(8'h5A); end
    used = (count > 512) ? 512 : count;
    ca = ref_code(0, (used > 256) ? 256 : used);
    cb = ref_code(256, (used > 256) ? used - 256 : 0);
    w0 = {ca[23:16], ca[15:8]};
    w1 = {cb[15:8], ca[7:0]};
    w2 = {cb[7:0], cb[23:16]};
    put_mode(8'hD4);
    check({15'd0, res_mode}, 16'd1, {tag, " R8 res_mode set"});
    read_chk(w0, {tag, " R7 word0"});
    read_chk(w1, {tag, " R7 word1 R6"});
    read_chk(w2, {tag, " R7 word2"});
    read_chk(w0, {tag, " R8 wrap to word0"});
    put_mode(8'h94);
    check({15'd0, res_mode}, 16'd0, {tag, " R9 res_mode cleared"});
  endtask

  initial begin
    void'($urandom(32'h1D5C));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check({15'd0, res_mode}, 16'd0, "R1 res_mode after reset");
    check(res_word, 16'hFFFF, "R1 res_word after reset");
    run_sector(1, 512, 0, 8'h00, 0, "R6 erased");
    run_sector(2, 512, 0, 8'h01, 0, "R3 bit0 at byte0");
    run_sector(2, 512, 173, 8'h80, 0, "R3 bit7 at byte173");
    run_sector(2, 512, 300, 8'h24, 0, "R4 second half byte300");
    run_sector(2, 512, 255, 8'h10, 0, "R4 last byte of half A");
    run_sector(2, 512, 256, 8'h08, 0, "R4 first byte of half B");
    for (int s = 0; s < 3; s++) run_sector(0, 512, 0, 8'h00, 0, "R3 random sector");
    run_sector(0, 600, 0, 8'h00, 0, "R5 overflow bytes ignored");
    run_sector(0, 100, 0, 8'h00, 0, "R4 partial half");
    run_sector(0, 512, 0, 8'h00, 1, "R9 idle bytes ignored");
    run_sector(0, 512, 0, 8'h00, 0, "R2 clear after prior sector");
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule